// File: doc/BRIEF.md
# Mode-Selectable 4-Bit Arithmetic/Logic Unit

This is a purely combinational arithmetic/logic slice. A 4-bit opcode and a mode bit together pick one operation. Each opcode names a pair of operations: an arithmetic one and a bitwise logical one. The mode bit chooses between the two. Arithmetic operations feed the carry-in into a 4-bit addition and report the carry-out of that sum. Logical operations work bit by bit and take no notice of the carry-in.

Every arithmetic operation maps onto a single adder. Each opcode presents a pair of effective operands to that adder. The block reports the group generate and group propagate of that operand pair, so a wider adder can build its carry lookahead around this slice. An equality flag reads the result of the subtract operation. Opcodes that have no operation assigned pass operand `a` through unchanged.

Top module: `alu4_mode`

## Requirements
- R1: When `logic_mode`=1 the carry-in has no effect on `res`, and `carry_o` is 0.
- R2: Opcode 0000 gives `a`-1+`cin` in arithmetic mode and NOT `a` in logic mode.
- R3: Opcode 0110 gives `a`-`b`-1+`cin` in arithmetic mode and `a` XNOR `b` in logic mode.
- R4: Opcode 1001 gives `a`+`b`+`cin` in arithmetic mode and `a` XOR `b` in logic mode.
- R5: Opcode 1011 gives (`a` OR `b`)+`cin` in arithmetic mode and `a` OR `b` in logic mode.
- R6: Opcode 1100 gives `a`+`a`+`cin` in arithmetic mode and 0000 in logic mode.
- R7: Opcode 1111 gives `a`+`cin` in arithmetic mode and `a` in logic mode.
- R8: Arithmetic results are taken modulo 16. `carry_o` is bit 4 of the 5-bit sum, so for the subtract forms a 1 means no borrow.
- R9: Each opcode defines an effective operand pair (x, y), as follows. 0000 uses (a, 1111). 0110 uses (a, NOT b). 1001 uses (a, b). 1011 uses (a OR b, 0000). 1100 uses (a, a). 1111 and every unlisted opcode use (a, 0000). `grp_gen` is 1 when x+y is 16 or more. `grp_prop` is 1 when x XOR y is 1111. Both outputs are the same in either mode.
- R10: `a_eq_b` is 1 only when the opcode is 0110, `logic_mode`=0, `cin`=0 and `res`=1111. When it is 1, `a` equals `b`.
- R11: Unlisted opcodes return `a` in both modes, with `carry_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| op | input | 4 | Function select |
| logic_mode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| cin | input | 1 | Carry-in, used by arithmetic operations only |
| res | output | 4 | Result |
| carry_o | output | 1 | Carry-out of the arithmetic sum |
| grp_gen | output | 1 | Group generate of the effective operands |
| grp_prop | output | 1 | Group propagate of the effective operands |
| a_eq_b | output | 1 | Equality flag |

## Verification
The block has no registers, so every output settles in the same cycle as its inputs, with zero cycles of latency. The bench applies one input vector just after each rising edge and pushes the expected outputs into a queue at that moment. The monitor then pops and compares them at the following falling edge, which falls within the same cycle. The bench sweeps every opcode, both modes, both carry-in values and all operand pairs. Each output field is checked under its own requirement.

// File: rtl/alu4_mode.sv
module alu4_mode #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         logic_mode,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         carry_o,
  output logic         grp_gen,
  output logic         grp_prop,
  output logic         a_eq_b
);
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] x, y, lres;
  logic         known;
  logic [W:0]   sum, gsum;

  always_comb begin
    known = 1'b1;
    x = a;
    y = ZERO;
    lres = a;
    unique case (op)
      4'b0000: begin y = ONES; lres = ~a;      end
      4'b0110: begin y = ~b;   lres = ~(a ^ b); end
      4'b1001: begin y = b;    lres = a ^ b;    end
      4'b1011: begin x = a | b; lres = a | b;   end
      4'b1100: begin y = a;    lres = ZERO;     end
      4'b1111: begin           lres = a;        end
      default: known = 1'b0;
    endcase
  end

  assign sum      = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign gsum     = {1'b0, x} + {1'b0, y};
  assign grp_gen  = gsum[W];
  assign grp_prop = &(x ^ y);

  assign res     = logic_mode ? lres : (known ? sum[W-1:0] : a);
  assign carry_o = known & ~logic_mode & sum[W];
  assign a_eq_b  = (op == 4'b0110) & ~logic_mode & ~cin & (&res);

  always_comb begin
    if (known && !logic_mode)
      a_r8_carry_lookahead: assert (carry_o == (grp_gen | (grp_prop & cin)));
    if (a_eq_b)
      a_r10_equal_operands: assert (a == b);
    if (!known)
      a_r11_unlisted_pass: assert (res == a && !carry_o);
    if (logic_mode)
      a_r1_logic_no_carry: assert (!carry_o);
    if (grp_gen)
      a_r9_gen_excludes_prop: assert (!grp_prop);
  end
endmodule

// File: tb/alu4_mode_tb_top.sv
module alu4_mode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] a = '0, b = '0, op = '0;
  logic logic_mode = 1'b0, cin = 1'b0;
  logic [3:0] res;
  logic carry_o, grp_gen, grp_prop, a_eq_b;

  int checks = 0, errors = 0;
  bit drv_done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu4_mode dut_i (
    .a(a), .b(b), .op(op), .logic_mode(logic_mode), .cin(cin),
    .res(res), .carry_o(carry_o), .grp_gen(grp_gen),
    .grp_prop(grp_prop), .a_eq_b(a_eq_b)
  );

  function automatic logic [7:0] model(int av, int bv, int ov, bit mv, bit cv);
    int x, y, s, lr, f;
    bit kn, co, g, p, eq;
    kn = 1; x = av; y = 0; lr = av;
    case (ov)
      0:  begin y = 15; lr = (~av) & 15; end
      6:  begin y = (~bv) & 15; lr = (~(av ^ bv)) & 15; end
      9:  begin y = bv; lr = av ^ bv; end
      11: begin x = av | bv; lr = av | bv; end
      12: begin y = av; lr = 0; end
      15: lr = av;
      default: kn = 0;
    endcase
    s = x + y + int'(cv);
    f = mv ? lr : (kn ? s % 16 : av);
    co = kn && !mv && s >= 16;
    g = (x + y) >= 16;
    p = ((x ^ y) & 15) == 15;
    eq = ov == 6 && !mv && !cv && f == 15;
    return {f[3:0], co, g, p, eq};
  endfunction

  function automatic string op_tag(int ov, bit mv, bit cv);
    if (mv && cv) return "R1";
    case (ov)
      0: return "R2";
      6: return "R3";
      9: return "R4";
      11: return "R5";
      12: return "R6";
      15: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic drive(int av, int bv, int ov, bit mv, bit cv);
    @(posedge clk);
    #1;
    a = av[3:0]; b = bv[3:0]; op = ov[3:0]; logic_mode = mv; cin = cv;
    exp_q.push_back(model(av, bv, ov, mv, cv));
    tag_q.push_back(op_tag(ov, mv, cv));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    for (int o = 0; o < 16; o++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 2; c++)
          for (int i = 0; i < 256; i++)
            drive(i / 16, i % 16, o, bit'(m), bit'(c));
    drv_done = 1'b1;
  end

  initial begin
    logic [7:0] e;
    string t;
    @(negedge clk);
    check("R10", "reset-state a_eq_b", int'(a_eq_b), 0);
    check("R2", "reset-state res", int'(res), 15);
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "res", int'(res), int'(e[7:4]));
        check("R8", "carry_o", int'(carry_o), int'(e[3]));
        check("R9", "grp_gen", int'(grp_gen), int'(e[2]));
        check("R9", "grp_prop", int'(grp_prop), int'(e[1]));
        check("R10", "a_eq_b", int'(a_eq_b), int'(e[0]));
      end else if (drv_done) begin
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule